// File: doc/BRIEF.md
# Comma-Aligned Word Deserializer with Antiphase Word Clocks

This block sits behind a clock-and-data-recovery front end. It takes a retimed serial bit, qualified by a one-cycle bit strobe, and assembles it into parallel words of `WORD_W` bits. The bit received first lands in bit 0 of the word. When word alignment is enabled, a 10-bit window slides over the stream one bit position at a time. When it finds a positive-disparity comma, the word boundary moves to that comma.

Parallel words are presented on two word clocks, `wclk_a` and `wclk_b`. These are generated in the system clock domain as registered levels that are always complementary. Each of them runs at half the word rate. Every new word appears together with a rising edge of one of the two clocks, and the clocks take turns. A high or low phase is never shortened when the boundary moves. Instead the current phase is held across one or two word slots, and the words inside that stretch are dropped. The result is that the second comma of an alignment sequence, and every presented comma after it, arrive on a rising edge of `wclk_b`.

A line-valid input blanks the parallel output to all ones while the line is absent. It also blanks the comma flag.

Top module: `comma_deser`

## Requirements
- R1: After reset, `word_out` reads all ones, `comma_out` is 0, `wclk_a` is 0 and `wclk_b` is 1, until the first word is presented.
- R2: A bit is taken only in a cycle with `bit_stb` high. The first bit taken into a word appears on `word_out[0]` and the last one on `word_out[9]`. The word clocks never change in a cycle that follows one without a strobe.
- R3: A word counts as a comma when its received bits 0 to 6 are 0,0,1,1,1,1,1 (that is, `word_out[6:0] == 7'b1111100`), whatever bits 7 to 9 are. `comma_out` is high exactly while such a word is presented.
- R4: `wclk_b` is always the complement of `wclk_a`. Each presented word comes with a toggle of the pair, so successive words line up with rising edges of the two clocks in turn.
- R5: No high or low phase of the word clocks lasts fewer than `WORD_W` bit strobes. This holds during realignment as well.
- R6: With `sync_en` high, a comma found at a bit position other than the current boundary moves the boundary so that the comma ends a word. The stream then runs `K D1 K D2 K D3 ...`, and the first comma presented is the second comma sent. It is followed, in order, by the words sent after it.
- R7: With `sync_en` high, a comma word is presented only on a rising edge of `wclk_b`. Any comma that would fall on a rise of `wclk_a` is dropped and the phase is stretched. While such a stretch is pending, a non-comma word is presented only on a rise of `wclk_a`.
- R8: With `sync_en` low, the boundary runs freely every `WORD_W` strobes counted from reset. Every word is presented whatever commas it holds.
- R9: While `sig_ok` is low, `word_out` is 1111111111 and `comma_out` is 0. While `sig_ok` is high, the stored word passes through.
- R10: A comma pattern found inside the word that follows a comma word does not move the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_bit | input | 1 | Retimed serial data bit |
| bit_stb | input | 1 | High for one cycle for each valid bit |
| sync_en | input | 1 | Enables comma-driven word alignment |
| sig_ok | input | 1 | Line present; when low the outputs are blanked |
| word_out | output | WORD_W | Presented parallel word, bit 0 received first |
| comma_out | output | 1 | Presented word is a comma |
| wclk_a | output | 1 | Word clock A, half the word rate |
| wclk_b | output | 1 | Word clock B, complement of A |

## Verification
The bench builds the block with `WORD_W = 10` and a strobe every second system clock, and it sometimes adds idle gaps between strobes. It sweeps the arrival offset of the first comma over all ten bit positions, so every misaligned case of the stretch logic is reached, including both parity cases for the second comma. Separate runs cover free-running framing with odd offsets and irregular gaps, a comma pattern hidden in the word after a comma, and line-valid blanking on a comma word.

// File: rtl/cdsr_pkg.sv
package cdsr_pkg;

  // Boundary event: produced by the framer, consumed by the phase generator
  typedef struct packed {
    logic valid;   // a word ends on this strobe
    logic comma;   // that word is a comma
  } bnd_t;

  // Number of word boundaries during which a further comma cannot realign
  localparam int GUARD_WORDS = 2;

endpackage

// File: rtl/cdsr_shift.sv
module cdsr_shift #(
  parameter int              WORD_W  = 10,
  parameter int              CMA_W   = 7,
  parameter logic [CMA_W-1:0] CMA_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              ser_bit,
  output logic [WORD_W-1:0] win_nx,
  output logic              match_nx
);

  logic [WORD_W-1:0] sr_q;

  // Newest bit enters at the top, so the oldest bit sits at index 0
  always_comb begin
    win_nx = {ser_bit, sr_q[WORD_W-1:1]};
  end

  // Compare the oldest CMA_W bit positions against the comma pattern
  logic [CMA_W-1:0] hit_bits;
  for (genvar i = 0; i < CMA_W; i++) begin : g_cmp
    assign hit_bits[i] = (win_nx[i] == CMA_PAT[i]);
  end
  assign match_nx = &hit_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (bit_stb) begin
      sr_q <= win_nx;
    end
  end

endmodule

// File: rtl/cdsr_frame.sv
module cdsr_frame
  import cdsr_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic sync_en,
  input  logic match_nx,
  output bnd_t bnd
);

  localparam int              CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam int              GRD_W = $clog2(GUARD_WORDS + 1);
  localparam logic [GRD_W-1:0] GRD_SET = GRD_W'(GUARD_WORDS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GRD_W-1:0] grd_q, grd_d;
  logic             at_last, realign, hit;

  always_comb begin
    at_last = (cnt_q == LAST);
    realign = bit_stb & sync_en & match_nx & ~at_last & (grd_q == '0);
    hit     = bit_stb & (at_last | realign);

    bnd.valid = hit;
    bnd.comma = hit & match_nx;

    cnt_d = cnt_q;
    if (hit) begin
      cnt_d = '0;
    end else if (bit_stb) begin
      cnt_d = cnt_q + 1'b1;
    end

    grd_d = grd_q;
    if (hit) begin
      if (match_nx) begin
        grd_d = GRD_SET;
      end else if (grd_q != '0) begin
        grd_d = grd_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      grd_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      grd_q <= grd_d;
    end
  end

endmodule

// File: rtl/cdsr_phase.sv
module cdsr_phase
  import cdsr_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int PC_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              sync_en,
  input  bnd_t              bnd,
  input  logic [WORD_W-1:0] win_nx,
  output logic [WORD_W-1:0] word_q,
  output logic              comma_q,
  output logic              wclk_a,
  output logic              wclk_b
);

  localparam logic [PC_W-1:0] PC_FULL = PC_W'(WORD_W - 1);
  localparam logic [PC_W-1:0] PC_MAX  = '1;

  logic [PC_W-1:0]   pc_q, pc_d;
  logic              pend_q, pend_d;
  logic [WORD_W-1:0] word_d;
  logic              comma_d, a_d, b_d;
  logic              full, edge_ok, present;

  always_comb begin
    // a phase may end only once WORD_W strobes have passed in it
    full = (pc_q >= PC_FULL);

    // which clock would rise: wclk_a rises when it is currently low
    if (!sync_en) begin
      edge_ok = 1'b1;
    end else if (bnd.comma) begin
      edge_ok = wclk_a;
    end else if (pend_q) begin
      edge_ok = ~wclk_a;
    end else begin
      edge_ok = 1'b1;
    end
    present = bnd.valid & full & edge_ok;

    word_d  = word_q;
    comma_d = comma_q;
    a_d     = wclk_a;
    b_d     = wclk_b;
    pc_d    = pc_q;
    pend_d  = pend_q;

    if (present) begin
      word_d  = win_nx;
      comma_d = bnd.comma;
      a_d     = ~wclk_a;
      b_d     = wclk_a;
      pc_d    = '0;
      pend_d  = 1'b0;
    end else begin
      if (bnd.valid & sync_en & (bnd.comma | pend_q)) begin
        pend_d = 1'b1;
      end
      if (bit_stb && (pc_q != PC_MAX)) begin
        pc_d = pc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '1;
      comma_q <= 1'b0;
      wclk_a  <= 1'b0;
      wclk_b  <= 1'b1;
      pc_q    <= '0;
      pend_q  <= 1'b0;
    end else begin
      word_q  <= word_d;
      comma_q <= comma_d;
      wclk_a  <= a_d;
      wclk_b  <= b_d;
      pc_q    <= pc_d;
      pend_q  <= pend_d;
    end
  end

endmodule

// File: rtl/comma_deser.sv
module comma_deser
  import cdsr_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int CMA_W  = 7,
  parameter logic [CMA_W-1:0] CMA_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_bit,
  input  logic              bit_stb,
  input  logic              sync_en,
  input  logic              sig_ok,
  output logic [WORD_W-1:0] word_out,
  output logic              comma_out,
  output logic              wclk_a,
  output logic              wclk_b
);

  localparam int PC_W = $clog2(4 * WORD_W);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[1];

  logic [WORD_W-1:0] win_nx;
  logic              match_nx;
  bnd_t              bnd;
  logic [WORD_W-1:0] word_q;
  logic              comma_q;

  cdsr_shift #(
    .WORD_W (WORD_W),
    .CMA_W  (CMA_W),
    .CMA_PAT(CMA_PAT)
  ) i_shift (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .bit_stb (bit_stb),
    .ser_bit (ser_bit),
    .win_nx  (win_nx),
    .match_nx(match_nx)
  );

  cdsr_frame #(
    .WORD_W(WORD_W)
  ) i_frame (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .bit_stb (bit_stb),
    .sync_en (sync_en),
    .match_nx(match_nx),
    .bnd     (bnd)
  );

  cdsr_phase #(
    .WORD_W(WORD_W),
    .PC_W  (PC_W)
  ) i_phase (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .bit_stb(bit_stb),
    .sync_en(sync_en),
    .bnd    (bnd),
    .win_nx (win_nx),
    .word_q (word_q),
    .comma_q(comma_q),
    .wclk_a (wclk_a),
    .wclk_b (wclk_b)
  );

  // Line absent: blank the word to all ones and hide the comma flag
  always_comb begin
    word_out  = sig_ok ? word_q : '1;
    comma_out = sig_ok & comma_q;
  end

endmodule

// File: rtl/cdsr_chk.sv
module cdsr_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_stb,
  input logic              sync_en,
  input logic              sig_ok,
  input logic [WORD_W-1:0] word_out,
  input logic              comma_out,
  input logic              wclk_a,
  input logic              wclk_b
);

  logic       prev_a;
  logic [7:0] pcnt;

  // Strobes counted in the current phase, the toggling strobe included
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a <= 1'b0;
      pcnt   <= '0;
    end else begin
      prev_a <= wclk_a;
      if (wclk_a != prev_a) begin
        pcnt <= bit_stb ? 8'd1 : 8'd0;
      end else if (bit_stb && (pcnt != 8'hFF)) begin
        pcnt <= pcnt + 8'd1;
      end
    end
  end

  AST_MIN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wclk_a != prev_a) |-> (pcnt >= 8'(WORD_W)));                       // R5

  AST_ANTIPHASE: assert property (@(posedge clk) disable iff (!rst_n)
    wclk_b == !wclk_a);                                                 // R4

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(wclk_a));                                      // R2

  AST_COMMA_ON_B: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wclk_a) && $past(sync_en)) |-> !comma_out);                  // R7

  AST_BLANK_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_ok |-> ((&word_out) && !comma_out));                           // R9

endmodule

bind comma_deser cdsr_chk #(.WORD_W(WORD_W)) i_cdsr_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .bit_stb  (bit_stb),
  .sync_en  (sync_en),
  .sig_ok   (sig_ok),
  .word_out (word_out),
  .comma_out(comma_out),
  .wclk_a   (wclk_a),
  .wclk_b   (wclk_b)
);

// File: tb/test_comma_deser.sv
`timescale 1ns/1ps
module test_comma_deser;

  localparam int WW = 10;
  localparam logic [WW-1:0] K  = 10'h17C;
  localparam logic [WW-1:0] D1 = 10'h155;
  localparam logic [WW-1:0] D2 = 10'h0CC;
  localparam logic [WW-1:0] D3 = 10'h133;
  localparam logic [WW-1:0] D4 = 10'h2D2;
  localparam logic [WW-1:0] XH = 10'h3E5;   // comma pattern at bits 3..9

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, ser_bit, bit_stb, sync_en, sig_ok;
  logic [WW-1:0] word_out;
  logic          comma_out, wclk_a, wclk_b;

  comma_deser i_comma_deser (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .bit_stb(bit_stb),
    .sync_en(sync_en), .sig_ok(sig_ok), .word_out(word_out),
    .comma_out(comma_out), .wclk_a(wclk_a), .wclk_b(wclk_b)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // capture of presented words
  logic [WW-1:0] cap_w [0:63];
  logic          cap_c [0:63];
  logic          cap_ra[0:63];
  int            ncap;
  logic          mon_on = 1'b0;
  logic          last_a;
  bit            seen_first;
  int            cyc_since;
  logic          bits [0:255];
  int            nbits;

  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      cyc_since++;
      if (wclk_a !== last_a) begin
        check(wclk_b === ~wclk_a, "R4 antiphase at toggle", WW'(wclk_b), WW'(~wclk_a));
        if (seen_first)
          check(cyc_since >= 2 * WW, "R5 phase length in cycles",
                WW'(cyc_since), WW'(2 * WW));
        if (ncap < 64) begin
          cap_w[ncap]  = word_out;
          cap_c[ncap]  = comma_out;
          cap_ra[ncap] = wclk_a;
          ncap++;
        end
        cyc_since  = 0;
        seen_first = 1'b1;
        last_a     = wclk_a;
      end
    end
  end

  task automatic do_reset(input logic se);
    mon_on  = 1'b0;
    rst_n   = 1'b0;
    sync_en = se;
    sig_ok  = 1'b1;
    bit_stb = 1'b0;
    ser_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ncap       = 0;
    nbits      = 0;
    last_a     = wclk_a;
    seen_first = 1'b0;
    cyc_since  = 0;
    mon_on     = 1'b1;
  endtask

  task automatic send_bit(input logic b, input int gap);
    @(negedge clk);
    ser_bit = b;
    bit_stb = 1'b1;
    if (nbits < 256) bits[nbits] = b;
    nbits++;
    @(negedge clk);
    bit_stb = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_word(input logic [WW-1:0] w, input int gap);
    for (int i = 0; i < WW; i++) send_bit(w[i], gap);
  endtask

  task automatic flush();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog for all requirements actual=timeout expected=done");
    report();
    $finish;
  end

  initial begin
    // ---------------- reset state
    do_reset(1'b1);
    check(word_out === '1, "R1 reset word", word_out, '1);
    check(comma_out === 1'b0, "R1 reset comma flag", WW'(comma_out), '0);
    check(wclk_a === 1'b0 && wclk_b === 1'b1, "R1 reset clocks",
          WW'({wclk_a, wclk_b}), WW'(2'b01));

    // ---------------- free-running framing, odd offset, irregular gaps
    do_reset(1'b0);
    send_bit(1'b1, 0); send_bit(1'b0, 2); send_bit(1'b1, 1);
    send_word(K, 1); send_word(D1, 0); send_word(K, 2); send_word(D2, 0);
    flush();
    check(ncap == 4, "R8 words presented free-running", WW'(ncap), WW'(4));
    for (int j = 0; j < 4; j++) begin
      logic [WW-1:0] e;
      for (int b = 0; b < WW; b++) e[b] = bits[WW * j + b];
      check(cap_w[j] === e, "R2 bit order, free-running chunk", cap_w[j], e);
      check(cap_c[j] === (e[6:0] == 7'b1111100), "R3 comma flag on chunk",
            WW'(cap_c[j]), WW'(e[6:0] == 7'b1111100));
    end

    // ---------------- realignment sweep over every bit offset
    for (int k = 0; k < WW; k++) begin
      int ci;
      do_reset(1'b1);
      for (int j = 0; j < k; j++) send_bit(1'b0, 0);
      send_word(K, 0); send_word(D1, 0); send_word(K, 0); send_word(D2, 0);
      send_word(K, 0); send_word(D3, 0); send_word(K, 0); send_word(D4, 0);
      flush();
      ci = -1;
      for (int j = ncap - 1; j >= 0; j--) if (cap_c[j]) ci = j;
      check(ci >= 0 && ci + 3 < ncap, "R6 comma presented after realign",
            WW'(ci), WW'(0));
      if (ci >= 0 && ci + 3 < ncap) begin
        check(cap_w[ci] === K, "R3 comma word value", cap_w[ci], K);
        check(cap_ra[ci] === 1'b0, "R7 first comma on wclk_b rise",
              WW'(cap_ra[ci]), WW'(0));
        check(cap_w[ci + 1] === D2, "R6 word after second comma", cap_w[ci + 1], D2);
        check(cap_w[ci + 2] === K,  "R6 third comma in order", cap_w[ci + 2], K);
        check(cap_w[ci + 3] === D3, "R6 data after third comma", cap_w[ci + 3], D3);
      end
      for (int j = 0; j < ncap; j++)
        if (cap_c[j]) check(cap_ra[j] === 1'b0, "R7 every comma on wclk_b",
                            WW'(cap_ra[j]), WW'(0));
    end

    // ---------------- comma pattern inside the word after a comma
    do_reset(1'b1);
    send_word(K, 0); send_word(D1, 0); send_word(K, 0); send_word(XH, 0);
    send_word(D2, 0); send_word(D3, 0); send_word(D4, 0);
    flush();
    check(ncap == 6, "R10 presented count", WW'(ncap), WW'(6));
    if (ncap >= 6) begin
      check(cap_w[0] === D1, "R10 word 0", cap_w[0], D1);
      check(cap_w[1] === K,  "R10 word 1", cap_w[1], K);
      check(cap_w[2] === XH, "R10 hidden-pattern word kept", cap_w[2], XH);
      check(cap_c[2] === 1'b0, "R3 hidden pattern not flagged", WW'(cap_c[2]), '0);
      check(cap_w[3] === D2, "R10 boundary unchanged", cap_w[3], D2);
      check(cap_w[4] === D3, "R10 word 4", cap_w[4], D3);
      check(cap_w[5] === D4, "R10 word 5", cap_w[5], D4);
    end

    // ---------------- line-valid blanking
    do_reset(1'b0);
    send_word(D1, 0); send_word(D2, 0);
    sig_ok = 1'b0;
    send_word(K, 0); send_word(D3, 0);
    sig_ok = 1'b1;
    send_word(D4, 0);
    flush();
    check(ncap == 5, "R9 presented count", WW'(ncap), WW'(5));
    if (ncap >= 5) begin
      check(cap_w[1] === D2, "R9 passthrough before blank", cap_w[1], D2);
      check(cap_w[2] === '1, "R9 blanked comma word", cap_w[2], '1);
      check(cap_c[2] === 1'b0, "R9 comma flag hidden", WW'(cap_c[2]), '0);
      check(cap_w[3] === '1, "R9 blanked data word", cap_w[3], '1);
      check(cap_w[4] === D4, "R9 passthrough after blank", cap_w[4], D4);
    end
    sig_ok = 1'b0;
    repeat (3) @(negedge clk);
    check(word_out === '1, "R9 static blank", word_out, '1);
    sig_ok = 1'b1;
    @(negedge clk);
    check(word_out === D4, "R9 stored word returns", word_out, D4);

    report();
    $finish;
  end

endmodule